// File: doc/BRIEF.md
# Programmable CIC Interpolation Stage

This stage raises complex baseband I/Q data to the system clock rate by an integer factor R chosen at reset. It uses a five-section cascaded integrator-comb structure, so the filtering itself needs no multipliers. The comb sections run at the low input rate. Their result is zero-stuffed into the integrator sections, which produce one I/Q pair on every system clock. A single small multiplier then removes the R^4 DC gain of the integrator-comb cascade, with saturation to the output width.

The stage sits behind a fixed 4x interpolator, so R from 2 to 63 gives a total rate change of 8x to 252x in steps of 4. A rate of 1 (or 0) takes the stage out of the path: input samples go straight to the output. In that case the stage also raises a flag that tells the droop-compensation filter in front of it to bypass too. The stage owns the low-rate timebase. A phase counter decides on which clock a new sample enters the filter. The newest sample marked by `in_valid` is the one used.

Top module: `cic_interp`

## Requirements
- R1: With a captured rate of 0 or 1, `out_i`/`out_q` equal `in_i`/`in_q` from one clock earlier, bit for bit, whatever `in_valid` does.
- R2: `comp_bypass` is 1 when the captured rate is 0 or 1 and 0 for rates 2..63.
- R3: `rate_sel` is captured only while `rst_n` is low. Changing it during operation has no effect on the output or on `comp_bypass` until the next reset.
- R4: A phase counter starts at 0 on the first clock after reset and wraps at R-1. A sample enters the filter on each clock where the counter is 0. That sample is the one presented with `in_valid` on that same clock, or else the last one presented earlier. Both paths give the same delay from entry to output.
- R5: For a single nonzero sample, the output follows the five-fold convolution of an R-long box, divided by R^4. It lasts exactly 5(R-1)+1 clocks and is zero afterwards. For R a power of two this holds exactly.
- R6: For a constant input x and any R in 2..63, the settled output is within |x|/256 + 1 of x.
- R7: Results beyond the signed 16-bit range saturate to 32767 or -32768.
- R8: The I and Q lanes are processed identically and independently.
- R9: While `rst_n` is low at a clock edge, both outputs are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one output pair per cycle |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the rate is captured |
| rate_sel | input | 6 | Interpolation factor R; 0 or 1 selects bypass |
| in_valid | input | 1 | Marks a new low-rate sample on `in_i`/`in_q` |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_i | output | 16 | In-phase output at the system rate, signed |
| out_q | output | 16 | Quadrature output at the system rate, signed |
| comp_bypass | output | 1 | Tells the droop-compensation filter to bypass |

## Verification
A fresh `in_valid` can arrive on the same clock as the phase counter's entry slot. In that case the new sample must go into the filter directly, not the held one. The bench provokes this by sending one impulse exactly on the entry clock, and another one cycle later, which must wait in the hold register for the next slot. Both responses must have the same shape. The delay from the entry clock to the first nonzero output must also be the same in both cases.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and elaboration-time helpers for the CIC
// interpolation stage. The helpers derive the gain-normalisation shift and
// correction factor for a given rate and stage count.
package cic_pkg;

    // Fraction bits of the normalisation correction factor.
    localparam int CORR_FRAC = 9;

    // DC gain of an interpolating cascade: rate^(stages-1); rate < 1 treated as 1.
    function automatic longint gain_of(input int rate, input int stages);
        longint g;
        longint r;
        g = 1;
        r = (rate < 1) ? 1 : longint'(rate);
        for (int s = 1; s < stages; s++) begin
            g = g * r;
        end
        return g;
    endfunction

    // Power-of-two exponent that covers the DC gain.
    function automatic int shift_of(input int rate, input int stages);
        return $clog2(gain_of(rate, stages));
    endfunction

    // Rounded correction factor: 2^(shift+frac) / gain, in [2^frac, 2^(frac+1)].
    function automatic int corr_of(input int rate, input int stages, input int frac);
        longint g;
        longint num;
        g   = gain_of(rate, stages);
        num = longint'(1) << (shift_of(rate, stages) + frac);
        return int'((num + g / 2) / g);
    endfunction

endpackage

// File: rtl/cic_rate_ctl.sv
`timescale 1ns/1ps
// Module: cic_rate_ctl
// Captures the interpolation rate while reset is held and derives the bypass
// decision. Runs the low-rate phase counter whose zero phase marks the clock
// on which a new sample enters the filter.
// Assumes: the rate is only meant to change across a reset.
module cic_rate_ctl #(
    parameter int RATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_q,
    output logic              bypass,
    output logic              take
);

    logic [RATE_W-1:0] phase_q;

    // Latch the requested rate only during reset so running state stays coherent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= rate_in;
        end
    end

    assign bypass = (rate_q <= RATE_W'(1));

    // Phase counter: counts 0..R-1 and parks at zero when bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (bypass || (phase_q == rate_q - RATE_W'(1))) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + RATE_W'(1);
        end
    end

    assign take = !bypass && (phase_q == '0);

    // R3
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rate_q));

    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (phase_q < rate_q));

    // R4
    take_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
// Module: cic_comb_chain
// Low-rate part of the interpolator: holds the newest sample and runs it
// through STAGES first-difference sections when the phase slot comes. It
// emits the result for exactly one clock, zero otherwise (zero-stuffing).
// Assumes: 'take' pulses at most once per R clocks; ACC_W covers bit growth.
module cic_comb_chain #(
    parameter int IN_W   = 16,
    parameter int ACC_W  = 46,
    parameter int STAGES = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    take,
    input  logic signed [IN_W-1:0]  x_in,
    output logic signed [ACC_W-1:0] stuffed
);

    logic signed [IN_W-1:0]  hold_q;
    logic signed [IN_W-1:0]  cur;
    logic signed [ACC_W-1:0] tap [STAGES+1];

    // Keep the newest presented sample for a later phase slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= x_in;
        end
    end

    // A sample arriving on the slot itself goes in directly.
    assign cur    = load ? x_in : hold_q;
    assign tap[0] = {{(ACC_W-IN_W){cur[IN_W-1]}}, cur};

    for (genvar k = 0; k < STAGES; k++) begin : g_comb
        logic signed [ACC_W-1:0] dly_q;

        // Remember this section's previous input at each phase slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (take) begin
                dly_q <= tap[k];
            end
        end

        assign tap[k+1] = tap[k] - dly_q;
    end

    // Insert the comb result on the slot and zeros on all other clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuffed <= '0;
        end else if (take) begin
            stuffed <= tap[STAGES];
        end else begin
            stuffed <= '0;
        end
    end

endmodule

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
// Module: cic_integ_chain
// High-rate part of the interpolator: STAGES registered accumulators in
// series, each adding the previous section's register (one clock per stage).
// Assumes: modular two's-complement wrap; the final sum fits ACC_W bits.
module cic_integ_chain #(
    parameter int ACC_W  = 46,
    parameter int STAGES = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] x_in,
    output logic signed [ACC_W-1:0] y_out
);

    logic signed [ACC_W-1:0] feed [STAGES+1];

    assign feed[0] = x_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_int
        logic signed [ACC_W-1:0] acc_q;

        // Accumulate the upstream value every system clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_q + feed[k];
            end
        end

        assign feed[k+1] = acc_q;
    end

    assign y_out = feed[STAGES];

endmodule

// File: rtl/cic_norm.sv
`timescale 1ns/1ps
// Module: cic_norm
// Removes the cascade's DC gain: multiplies by a rate-dependent correction
// factor (registered), then shifts right arithmetically and saturates to the
// output width. The saturated result is combinational from the product.
// Assumes: corr and shift are stable while running.
module cic_norm #(
    parameter int ACC_W   = 46,
    parameter int OUT_W   = 16,
    parameter int CORR_W  = 11,
    parameter int SHIFT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_in,
    input  logic [CORR_W-1:0]       corr,
    input  logic [SHIFT_W-1:0]      shift,
    output logic signed [OUT_W-1:0] y_out
);

    localparam int PROD_W = ACC_W + CORR_W + 1;
    localparam logic signed [PROD_W-1:0] HI_LIM =
        {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] LO_LIM =
        {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod_q;
    logic signed [PROD_W-1:0] scaled;

    // Scale the integrator sum by the correction factor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else begin
            prod_q <= PROD_W'(acc_in) * PROD_W'($signed({1'b0, corr}));
        end
    end

    assign scaled = prod_q >>> shift;

    // Clamp the shifted value into the output range.
    always_comb begin
        if (scaled > HI_LIM) begin
            y_out = HI_LIM[OUT_W-1:0];
        end else if (scaled < LO_LIM) begin
            y_out = LO_LIM[OUT_W-1:0];
        end else begin
            y_out = scaled[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/cic_interp.sv
`timescale 1ns/1ps
// Module: cic_interp (top)
// Programmable CIC interpolator for an I/Q pair. Comb sections at the low
// rate, zero-stuffing, integrator sections at the system rate, then gain
// normalisation. A rate of 0 or 1 routes the input straight to the output
// register and flags the compensation filter to bypass.
// Assumes: rate_sel is set up during reset; the upstream presents about one
// sample per R clocks.
module cic_interp #(
    parameter int DATA_W = 16,
    parameter int RATE_W = 6,
    parameter int STAGES = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RATE_W-1:0]        rate_sel,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic                     comp_bypass
);

    localparam int R_MAX   = (1 << RATE_W) - 1;
    localparam int ACC_W   = DATA_W + STAGES * RATE_W;
    localparam int CORR_W  = cic_pkg::CORR_FRAC + 2;
    localparam int SHIFT_W = $clog2(STAGES * RATE_W + cic_pkg::CORR_FRAC + 1);
    localparam int LANES   = 2;

    logic [RATE_W-1:0] rate_q;
    logic              bypass;
    logic              take;

    cic_rate_ctl #(.RATE_W(RATE_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_in (rate_sel),
        .rate_q  (rate_q),
        .bypass  (bypass),
        .take    (take)
    );

    // Normalisation constants per rate, computed at elaboration.
    logic [CORR_W-1:0]  corr_tab  [R_MAX+1];
    logic [SHIFT_W-1:0] shift_tab [R_MAX+1];

    for (genvar r = 0; r <= R_MAX; r++) begin : g_tab
        assign corr_tab[r]  = CORR_W'(cic_pkg::corr_of(r, STAGES, cic_pkg::CORR_FRAC));
        assign shift_tab[r] = SHIFT_W'(cic_pkg::shift_of(r, STAGES) + cic_pkg::CORR_FRAC);
    end

    logic [CORR_W-1:0]  corr_sel;
    logic [SHIFT_W-1:0] shift_sel;

    assign corr_sel  = corr_tab[rate_q];
    assign shift_sel = shift_tab[rate_q];

    logic signed [DATA_W-1:0] lane_in  [LANES];
    logic signed [DATA_W-1:0] lane_out [LANES];
    logic signed [ACC_W-1:0]  lane_acc [LANES];

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic signed [ACC_W-1:0]  stuffed;
        logic signed [DATA_W-1:0] norm_y;
        logic signed [DATA_W-1:0] out_q_r;

        cic_comb_chain #(.IN_W(DATA_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (in_valid),
            .take    (take),
            .x_in    (lane_in[ln]),
            .stuffed (stuffed)
        );

        cic_integ_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
            .clk   (clk),
            .rst_n (rst_n),
            .x_in  (stuffed),
            .y_out (lane_acc[ln])
        );

        cic_norm #(.ACC_W(ACC_W), .OUT_W(DATA_W), .CORR_W(CORR_W), .SHIFT_W(SHIFT_W)) u_norm (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc_in (lane_acc[ln]),
            .corr   (corr_sel),
            .shift  (shift_sel),
            .y_out  (norm_y)
        );

        // Output register: raw input when bypassed, normalised result otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q_r <= '0;
            end else if (bypass) begin
                out_q_r <= lane_in[ln];
            end else begin
                out_q_r <= norm_y;
            end
        end

        assign lane_out[ln] = out_q_r;
    end

    assign out_i       = lane_out[0];
    assign out_q       = lane_out[1];
    assign comp_bypass = bypass;

    // R1
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && $past(rst_n)) |-> (out_i == $past(in_i) && out_q == $past(in_q)));

    // R1
    idle_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (lane_acc[0] == '0 && lane_acc[1] == '0));

endmodule

// File: tb/cic_interp_tb.sv
`timescale 1ns/1ps
// Bench for cic_interp: directed impulse, saturation and rate-hold cases,
// plus seeded random DC and bypass traffic, checked against bench models.
module cic_interp_tb;

    localparam int DW = 16;
    localparam int RW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [RW-1:0]        rate_sel = '0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic signed [DW-1:0] out_i;
    logic signed [DW-1:0] out_q;
    logic                 comp_bypass;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cic_interp u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .in_valid    (in_valid),
        .in_i        (in_i),
        .in_q        (in_q),
        .out_i       (out_i),
        .out_q       (out_q),
        .comp_bypass (comp_bypass)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(input int got, input int want);
        int d;
        int lim;
        d   = (got > want) ? got - want : want - got;
        lim = ((want < 0) ? -want : want) / 256 + 1;
        return d <= lim;
    endfunction

    // Coefficient j of five cascaded length-r boxes.
    function automatic int box(input int r, input int j);
        int c [64];
        int t [64];
        for (int i = 0; i < 64; i++) c[i] = 0;
        c[0] = 1;
        repeat (5) begin
            for (int i = 0; i < 64; i++) t[i] = 0;
            for (int i = 0; i < 64; i++)
                for (int a = 0; a < r; a++)
                    if (i + a < 64) t[i+a] += c[i];
            c = t;
        end
        return c[j];
    endfunction

    // Reset with a rate; checks R9 and R2, returns at the negedge of release.
    task automatic start(input int r);
        rst_n    = 1'b0;
        rate_sel = RW'(r);
        in_valid = 1'b0;
        in_i     = '0;
        in_q     = '0;
        repeat (3) @(negedge clk);
        check(out_i == 0 && out_q == 0, "R9", "outputs in reset", int'(out_i), 0);
        check(comp_bypass == (r <= 1), "R2", "comp_bypass", int'(comp_bypass), int'(r <= 1));
        rst_n = 1'b1;
    endtask

    // Constant input run; returns after settling.
    task automatic dc_run(input int r, input int xi, input int xq, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            in_valid = (k % r == 0);
            in_i     = DW'(xi);
            in_q     = DW'(xq);
            @(negedge clk);
        end
    endtask

    task automatic dc_test(input int r, input int xi, input int xq);
        start(r);
        dc_run(r, xi, xq, 8 * r + 40);
        check(near(int'(out_i), xi), "R6", $sformatf("DC I r=%0d", r), int'(out_i), xi);
        check(near(int'(out_q), xq), "R8", $sformatf("DC Q r=%0d", r), int'(out_q), xq);
    endtask

    // Impulse presented at phase 'off'; returns delay from entry slot to first output.
    task automatic impulse(input int r, input int off, output int lat);
        int oi [120];
        int oq [120];
        int inj;
        int first;
        int len;
        int hv;
        start(r);
        for (int k = 0; k < 120; k++) begin
            in_valid = (k % r == off);
            in_i     = (k == 2 * r + off) ? DW'(16384) : '0;
            in_q     = (k == 2 * r + off) ? DW'(-8192) : '0;
            @(negedge clk);
            oi[k] = int'(out_i);
            oq[k] = int'(out_q);
        end
        in_valid = 1'b0;
        inj   = (off == 0) ? 2 * r : 3 * r;
        first = -1;
        for (int k = 0; k < 120; k++) if (first < 0 && oi[k] != 0) first = k;
        lat = first - inj;
        check(first >= 0, "R5", "impulse seen", first, 0);
        if (first >= 0) begin
            len = 5 * (r - 1) + 1;
            for (int j = 0; j < len + 4 && first + j < 120; j++) begin
                hv = (j < len) ? box(r, j) : 0;
                check(oi[first+j] == (16384 / (r ** 4)) * hv, "R5",
                      $sformatf("impulse I r=%0d tap %0d", r, j), oi[first+j], (16384 / (r ** 4)) * hv);
                check(oq[first+j] == (-8192 / (r ** 4)) * hv, "R8",
                      $sformatf("impulse Q r=%0d tap %0d", r, j), oq[first+j], (-8192 / (r ** 4)) * hv);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int la;
        int lb;
        int pi;
        int pq;
        void'($urandom(32'd4242));

        // R5, R8: exact impulse shapes at power-of-two rates.
        impulse(2, 0, la);
        impulse(4, 0, la);
        // R4: same impulse one and two clocks after the slot goes via the hold.
        impulse(4, 1, lb);
        check(lb == la, "R4", "entry-to-output delay, held sample", lb, la);
        impulse(4, 2, lb);
        check(lb == la, "R4", "entry-to-output delay, late sample", lb, la);

        // R6, R8: directed extremes of the rate range.
        dc_test(2, 12345, -23456);
        dc_test(63, -30000, 29999);
        dc_test(3, 1000, -1000);

        // R6, R8: random rates and levels.
        for (int n = 0; n < 8; n++) begin
            dc_test(2 + int'($urandom % 62),
                    int'($urandom % 60001) - 30000,
                    int'($urandom % 60001) - 30000);
        end

        // R7: gain slightly above one at R=5 clips full-scale input.
        start(5);
        dc_run(5, 32767, -32768, 80);
        check(out_i == 16'sd32767, "R7", "positive clip", int'(out_i), 32767);
        check(out_q == -16'sd32768, "R7", "negative clip", int'(out_q), -32768);

        // R3: rate changes while running are ignored.
        start(7);
        dc_run(7, 5000, -7000, 100);
        rate_sel = RW'(2);
        dc_run(7, 5000, -7000, 60);
        check(near(int'(out_i), 5000), "R3", "I after rate change", int'(out_i), 5000);
        check(comp_bypass == 1'b0, "R3", "flag after rate change", int'(comp_bypass), 0);
        rate_sel = RW'(1);
        dc_run(7, 5000, -7000, 60);
        check(near(int'(out_q), -7000), "R3", "Q after bypass request", int'(out_q), -7000);
        check(comp_bypass == 1'b0, "R3", "flag after bypass request", int'(comp_bypass), 0);

        // R1: bit-exact pass-through at rate 1 and 0.
        for (int rr = 0; rr < 2; rr++) begin
            start(1 - rr);
            for (int k = 0; k < 120; k++) begin
                in_valid = 1'($urandom % 2);
                in_i     = DW'($urandom);
                in_q     = DW'($urandom);
                pi       = int'(in_i);
                pq       = int'(in_q);
                @(negedge clk);
                check(int'(out_i) == pi, "R1", "bypass I", int'(out_i), pi);
                check(int'(out_q) == pq, "R1", "bypass Q", int'(out_q), pq);
            end
        end

        // R9: a final reset clears the outputs.
        start(9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule